// File: doc/BRIEF.md
# Bus Address Decoder with Built-in Error Responder

This block sits between a single bus master and a set of memory-mapped slaves on a 32-bit pipelined bus. Each cycle it decodes the address on the bus into a one-hot slave select. Three address windows belong to real slaves, and every address outside them selects a responder inside this block. The window bases and sizes are parameters, so an instance can be given a different memory map.

The bus is pipelined, so the response to an address phase comes in the following data phase. The block stores the index of the slave chosen in each accepted address phase and uses it to steer read data, ready and response from that slave back to the master. An address phase is accepted only when ready is high.

The built-in responder is a three-state machine:

- **FB_READY**: ready high, response OKAY.
- **FB_ERR_WAIT**: ready low, response ERROR.
- **FB_ERR_DONE**: ready high, response ERROR.

It moves through these states on four transitions:

- **accept_err**: FB_READY goes to FB_ERR_WAIT when an active transfer addressed to the responder is accepted.
- **finish_err**: FB_ERR_WAIT always goes to FB_ERR_DONE on the next edge.
- **chain_err**: FB_ERR_DONE goes to FB_ERR_WAIT when another active transfer to the responder is accepted.
- **release**: FB_ERR_DONE goes to FB_READY when no such transfer is accepted.

Top module: `bus_region_decoder`

## Requirements
- R1: Addresses 0x0000_0000 to 0x3FFF_FFFF, both ends included, assert select bit 1 (`hsel[1]`) and no other bit.
- R2: Addresses 0x5000_0000 to 0x5000_FFFF, both ends included, assert select bit 2 and no other bit.
- R3: Addresses 0xC000_0000 to 0xCFFF_FFFF, both ends included, assert select bit 3 and no other bit.
- R4: Every other address asserts select bit 0 (the built-in responder) and no other bit. Exactly one select bit is high in every cycle.
- R5: An accepted IDLE (htrans 2'b00) or BUSY (2'b01) transfer to the responder gets a zero-wait data phase with hready high and hresp OKAY (2'b00).
- R6: An accepted NONSEQ (2'b10) or SEQ (2'b11) transfer to the responder gets a two-cycle ERROR (hresp 2'b01). The first data cycle has hready low and the second has hready high.
- R7: In the data phase, hrdata, hready and hresp come from the slave selected in the last address phase that was accepted with hready high. The responder's read data is zero.
- R8: While hready is low, the stored data-phase selection holds, even if the address changes.
- R9: After reset, the data phase points to the responder: hready is 1, hresp is OKAY and hrdata is 0.
- R10: An active transfer to the responder that is presented during the second ERROR cycle starts a new two-cycle ERROR straight away.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| haddr | input | 32 | Address-phase address |
| htrans | input | 2 | Transfer type: 00 IDLE, 01 BUSY, 10 NONSEQ, 11 SEQ |
| hsel | output | 4 | One-hot select. Bit 0 is the responder; bits 1 to 3 are the slave windows |
| slv_rdata | input | 96 | Read data from slaves 1 to 3, slave 1 in the low 32 bits |
| slv_ready | input | 3 | Ready-out from slaves 1 to 3, slave 1 in bit 0 |
| slv_resp | input | 6 | Response from slaves 1 to 3, two bits each, slave 1 lowest |
| hrdata | output | 32 | Read data returned to the master |
| hready | output | 1 | Transfer-done indication to the master and to all slaves |
| hresp | output | 2 | Response to the master: 00 OKAY, 01 ERROR, 10 RETRY, 11 SPLIT |

## Verification
A stored data-phase index that is wrong shows up in the very next cycle: hrdata carries another slave's constant, or hready follows the wrong slave's wait state. A missed hold during a wait state appears one edge after the address changes. A responder stuck in the wrong state shows at the ports one cycle after the transfer is accepted: ERROR arrives without its low-ready first cycle, the second cycle is missing, or an ERROR appears after an IDLE. Decode faults show on hsel within the same cycle, which is why the window edges are driven exactly.

// File: rtl/busdec_pkg.sv
package busdec_pkg;

    localparam logic [1:0] TR_IDLE   = 2'b00;
    localparam logic [1:0] TR_BUSY   = 2'b01;
    localparam logic [1:0] TR_NONSEQ = 2'b10;
    localparam logic [1:0] TR_SEQ    = 2'b11;

    localparam logic [1:0] RS_OKAY   = 2'b00;
    localparam logic [1:0] RS_ERROR  = 2'b01;
    localparam logic [1:0] RS_RETRY  = 2'b10;
    localparam logic [1:0] RS_SPLIT  = 2'b11;

    typedef enum logic [1:0] {
        FB_READY    = 2'b00,
        FB_ERR_WAIT = 2'b01,
        FB_ERR_DONE = 2'b10
    } fb_state_e;

endpackage

// File: rtl/region_match.sv
module region_match #(
    parameter int unsigned AW   = 32,
    parameter int unsigned NREG = 3,
    parameter logic [NREG*AW-1:0] BASES = '0,
    parameter logic [NREG*AW-1:0] MASKS = '0,
    localparam int unsigned IDXW = $clog2(NREG + 1)
) (
    input  logic [AW-1:0]   addr,
    output logic [NREG:0]   sel,
    output logic [IDXW-1:0] idx
);

    logic [NREG-1:0] hit;

    // One comparator per window: clear the offset bits, then compare with the base.
    for (genvar g = 0; g < NREG; g++) begin : g_win
        assign hit[g] = ((addr & ~MASKS[g*AW +: AW]) == BASES[g*AW +: AW]);
    end

    // Bit 0 is the built-in responder; it takes any address no window claims.
    assign sel = {hit, ~|hit};

    always_comb begin
        idx = '0;
        for (int i = 0; i < NREG; i++) begin
            if (hit[i]) begin
                idx = IDXW'(i + 1);
            end
        end
    end

endmodule

// File: rtl/fallback_slave.sv
module fallback_slave
    import busdec_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sel,
    input  logic       bus_ready,
    input  logic [1:0] htrans,
    output logic       ready_out,
    output logic [1:0] resp_out
);

    fb_state_e state_q;
    fb_state_e state_d;
    logic      take_err;

    // An active transfer to the responder, accepted on this edge.
    assign take_err = sel && bus_ready && ((htrans == TR_NONSEQ) || (htrans == TR_SEQ));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= FB_READY;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FB_READY:    state_d = take_err ? FB_ERR_WAIT : FB_READY;    // accept_err
            FB_ERR_WAIT: state_d = FB_ERR_DONE;                          // finish_err
            FB_ERR_DONE: state_d = take_err ? FB_ERR_WAIT : FB_READY;    // chain_err / release
            default:     state_d = FB_READY;
        endcase
    end

    always_comb begin
        ready_out = 1'b1;
        resp_out  = RS_OKAY;
        unique case (state_q)
            FB_READY: begin
                ready_out = 1'b1;
                resp_out  = RS_OKAY;
            end
            FB_ERR_WAIT: begin
                ready_out = 1'b0;
                resp_out  = RS_ERROR;
            end
            FB_ERR_DONE: begin
                ready_out = 1'b1;
                resp_out  = RS_ERROR;
            end
            default: begin
                ready_out = 1'b1;
                resp_out  = RS_OKAY;
            end
        endcase
    end

endmodule

// File: rtl/resp_mux.sv
module resp_mux #(
    parameter int unsigned DW   = 32,
    parameter int unsigned NREG = 3,
    localparam int unsigned IDXW = $clog2(NREG + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_ready,
    input  logic [IDXW-1:0]   addr_idx,
    input  logic [NREG*DW-1:0] slv_rdata,
    input  logic [NREG-1:0]   slv_ready,
    input  logic [NREG*2-1:0] slv_resp,
    input  logic              fb_ready,
    input  logic [1:0]        fb_resp,
    output logic [IDXW-1:0]   dp_idx,
    output logic [DW-1:0]     rdata,
    output logic              ready,
    output logic [1:0]        resp
);

    // The slave index moves into the data phase only on accepted edges.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dp_idx <= '0;
        end else if (bus_ready) begin
            dp_idx <= addr_idx;
        end
    end

    // Index 0 is the responder, which returns zero read data.
    always_comb begin
        rdata = '0;
        ready = fb_ready;
        resp  = fb_resp;
        for (int i = 0; i < NREG; i++) begin
            if (dp_idx == IDXW'(i + 1)) begin
                rdata = slv_rdata[i*DW +: DW];
                ready = slv_ready[i];
                resp  = slv_resp[i*2 +: 2];
            end
        end
    end

endmodule

// File: rtl/bus_region_decoder.sv
module bus_region_decoder #(
    parameter int unsigned AW   = 32,
    parameter int unsigned DW   = 32,
    parameter int unsigned NREG = 3,
    parameter logic [NREG*AW-1:0] BASES = {32'hC000_0000, 32'h5000_0000, 32'h0000_0000},
    parameter logic [NREG*AW-1:0] MASKS = {32'h0FFF_FFFF, 32'h0000_FFFF, 32'h3FFF_FFFF}
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [AW-1:0]      haddr,
    input  logic [1:0]         htrans,
    output logic [NREG:0]      hsel,
    input  logic [NREG*DW-1:0] slv_rdata,
    input  logic [NREG-1:0]    slv_ready,
    input  logic [NREG*2-1:0]  slv_resp,
    output logic [DW-1:0]      hrdata,
    output logic               hready,
    output logic [1:0]         hresp
);

    localparam int unsigned IDXW = $clog2(NREG + 1);

    logic [IDXW-1:0] addr_idx;
    logic [IDXW-1:0] dp_idx;
    logic            fb_ready;
    logic [1:0]      fb_resp;

    region_match #(
        .AW    (AW),
        .NREG  (NREG),
        .BASES (BASES),
        .MASKS (MASKS)
    ) u_match (
        .addr (haddr),
        .sel  (hsel),
        .idx  (addr_idx)
    );

    fallback_slave u_fallback (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel       (hsel[0]),
        .bus_ready (hready),
        .htrans    (htrans),
        .ready_out (fb_ready),
        .resp_out  (fb_resp)
    );

    resp_mux #(
        .DW   (DW),
        .NREG (NREG)
    ) u_mux (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_ready (hready),
        .addr_idx  (addr_idx),
        .slv_rdata (slv_rdata),
        .slv_ready (slv_ready),
        .slv_resp  (slv_resp),
        .fb_ready  (fb_ready),
        .fb_resp   (fb_resp),
        .dp_idx    (dp_idx),
        .rdata     (hrdata),
        .ready     (hready),
        .resp      (hresp)
    );

endmodule

// File: rtl/bus_region_decoder_chk.sv
module bus_region_decoder_chk #(
    parameter int unsigned DW   = 32,
    parameter int unsigned NREG = 3,
    localparam int unsigned IDXW = $clog2(NREG + 1)
) (
    input logic               clk,
    input logic               rst_n,
    input logic [1:0]         htrans,
    input logic [NREG:0]      hsel,
    input logic [NREG*DW-1:0] slv_rdata,
    input logic [DW-1:0]      hrdata,
    input logic               hready,
    input logic [1:0]         hresp,
    input logic [IDXW-1:0]    dp_idx
);

    p_sel_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(hsel) == 1);

    p_idle_okay_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (hsel[0] && hready && !htrans[1]) |=> (hready && hresp == 2'b00));

    p_err_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (hsel[0] && hready && htrans[1]) |=> (!hready && hresp == 2'b01));

    p_err_second_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (dp_idx == '0 && !hready && hresp == 2'b01) |=> (hready && hresp == 2'b01));

    p_mux_slave1_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (hready && hsel[1]) |=> (hrdata == slv_rdata[0 +: DW]));

    p_hold_index_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !hready |=> $stable(dp_idx));

endmodule

bind bus_region_decoder bus_region_decoder_chk #(.DW(DW), .NREG(NREG)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .htrans    (htrans),
    .hsel      (hsel),
    .slv_rdata (slv_rdata),
    .hrdata    (hrdata),
    .hready    (hready),
    .hresp     (hresp),
    .dp_idx    (dp_idx)
);

// File: tb/sim_bus_region_decoder.sv
`timescale 1ns/1ps
module sim_bus_region_decoder;

    localparam logic [31:0] D1 = 32'hA1A1_0001;
    localparam logic [31:0] D2 = 32'hB2B2_0002;
    localparam logic [31:0] D3 = 32'hC3C3_0003;

    typedef struct {
        logic        rdy;
        logic [1:0]  rsp;
        logic [31:0] dat;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] haddr = '0;
    logic [1:0]  htrans = 2'b00;
    logic [3:0]  hsel;
    logic [95:0] slv_rdata;
    logic [2:0]  slv_ready = 3'b111;
    logic [5:0]  slv_resp = '0;
    logic [31:0] hrdata;
    logic        hready;
    logic [1:0]  hresp;

    int   n_checks = 0;
    int   n_errors = 0;
    exp_t exp_q[$];

    assign slv_rdata = {D3, D2, D1};

    always #5 clk = ~clk;

    bus_region_decoder u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .haddr     (haddr),
        .htrans    (htrans),
        .hsel      (hsel),
        .slv_rdata (slv_rdata),
        .slv_ready (slv_ready),
        .slv_resp  (slv_resp),
        .hrdata    (hrdata),
        .hready    (hready),
        .hresp     (hresp)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] expv);
        n_checks++;
        if (act !== expv) begin
            n_errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, expv);
        end
    endtask

    // Monitor: compare each data phase just after the edge that opens it.
    always @(posedge clk) begin
        #2;
        if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            chk({e.tag, " hready"}, {31'd0, hready}, {31'd0, e.rdy});
            chk({e.tag, " hresp"},  {30'd0, hresp},  {30'd0, e.rsp});
            chk({e.tag, " hrdata"}, hrdata, e.dat);
        end
    end

    // Driver: present one address phase, check the decode, queue the expected data phase.
    task automatic step(input logic [31:0] a, input logic [1:0] t, input logic [3:0] xsel,
                        input logic xr, input logic [1:0] xresp, input logic [31:0] xd,
                        input string tag);
        exp_t e;
        haddr  = a;
        htrans = t;
        #1;
        chk({tag, " hsel"}, {28'd0, hsel}, {28'd0, xsel});
        e.rdy = xr; e.rsp = xresp; e.dat = xd; e.tag = tag;
        exp_q.push_back(e);
        @(posedge clk);
        #4;
    endtask

    initial begin
        #2_000_000;
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #4;
        chk("R9 reset hready", {31'd0, hready}, 32'd1);
        chk("R9 reset hresp",  {30'd0, hresp},  32'd0);
        chk("R9 reset hrdata", hrdata, 32'd0);
        rst_n = 1'b1;
        @(posedge clk);
        #4;

        step(32'h0000_0000, 2'b10, 4'b0010, 1'b1, 2'b00, D1, "R1 low edge");
        step(32'h3FFF_FFFC, 2'b10, 4'b0010, 1'b1, 2'b00, D1, "R1 high edge");
        step(32'h4000_0000, 2'b00, 4'b0001, 1'b1, 2'b00, 32'd0, "R4 R5 idle unmapped");
        step(32'h5000_0000, 2'b10, 4'b0100, 1'b1, 2'b00, D2, "R2 low edge");
        step(32'h5000_FFFC, 2'b11, 4'b0100, 1'b1, 2'b00, D2, "R2 high edge");
        step(32'h5001_0000, 2'b01, 4'b0001, 1'b1, 2'b00, 32'd0, "R4 R5 busy past R2");
        step(32'hC000_0000, 2'b10, 4'b1000, 1'b1, 2'b00, D3, "R3 low edge");
        step(32'hCFFF_FFFC, 2'b10, 4'b1000, 1'b1, 2'b00, D3, "R3 high edge");
        // Two-cycle error, then a chained error, then a held address.
        step(32'hD000_0000, 2'b10, 4'b0001, 1'b0, 2'b01, 32'd0, "R6 err first");
        step(32'hD000_0000, 2'b10, 4'b0001, 1'b1, 2'b01, 32'd0, "R6 err second");
        step(32'hFFFF_FFF0, 2'b11, 4'b0001, 1'b0, 2'b01, 32'd0, "R10 chained err first");
        step(32'h1000_0000, 2'b10, 4'b0010, 1'b1, 2'b01, 32'd0, "R8 hold during err wait");
        step(32'h1000_0000, 2'b10, 4'b0010, 1'b1, 2'b00, D1, "R7 switch to slave1");
        // Slave wait state holds the data-phase index.
        slv_ready = 3'b101;
        step(32'h5000_0100, 2'b10, 4'b0100, 1'b0, 2'b00, D2, "R7 slave2 waits");
        step(32'hC000_0040, 2'b10, 4'b1000, 1'b0, 2'b00, D2, "R8 hold during slave wait");
        slv_ready = 3'b111;
        step(32'hC000_0040, 2'b10, 4'b1000, 1'b1, 2'b00, D3, "R7 slave3 after wait");
        step(32'hBFFF_FFFC, 2'b10, 4'b0001, 1'b0, 2'b01, 32'd0, "R4 R6 below R3 err");
        step(32'hBFFF_FFFC, 2'b00, 4'b0001, 1'b1, 2'b01, 32'd0, "R6 err second cycle");
        step(32'h0000_0400, 2'b00, 4'b0010, 1'b1, 2'b00, D1, "R1 R7 idle to slave1");
        step(32'h4FFF_FFFC, 2'b00, 4'b0001, 1'b1, 2'b00, 32'd0, "R4 R5 idle below R2");
        step(32'h4FFF_FFFC, 2'b00, 4'b0001, 1'b1, 2'b00, 32'd0, "R5 idle stays okay");

        @(posedge clk);
        #4;
        $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule